// File: doc/BRIEF.md
# Gate-Driver Fault Protection Sequencer

This block sits between a half-bridge dead-time interlock and the two gate drivers. It takes already-digitized protection inputs: a short-circuit comparator flag, a supply undervoltage pair for each side, an active-low shutdown request, and the sensed level of a wired fault line that several drivers share. From these it decides when to pull the shared fault line low, how the low-side gate should be driven, and whether the high-side gate may follow its command.

Each protection input must persist before it acts. A filter counter returns to zero whenever its input drops early, so a brief spike has no effect. An accepted short circuit or low-side undervoltage produces three results. A fault pulse of fixed length goes out on the line. The low-side gate moves to a soft turn-off, and the high-side gate is blocked. Shutdown and an external pull-down on the fault line are not filtered; both turn the gates off hard. After the pulse ends and every cause is gone, the low-side command has to be seen low once, and its next high command restores normal drive.

Each undervoltage channel has a separate assert flag and release flag. This gives hysteresis: a side stays blocked from reset, and after a trip, until its release flag is seen. Every time constant is a parameter counted in clock cycles.

Top module: `gate_fault_seq`

## Requirements
- R1: While reset is held and just after it is released, loMode is 2'b00 (off), hiGate is 0 and faultPull is 0. Both sides stay blocked after reset until their undervoltage release flag is seen high.
- R2: scDet is accepted only after SC_FILT_CYC consecutive high samples. A shorter high run is ignored. A drop of scDet for even one cycle restarts the count from zero.
- R3: One cycle after acceptance (SC_FILT_CYC+1 rising edges after the first high sample), loMode becomes 2'b10 (soft-off) if loCmd is high, faultPull becomes 1, and hiGate is forced to 0.
- R4: faultPull stays high for exactly PULSE_CYC cycles. A new fault event during the pulse does not lengthen it.
- R5: Soft-off (2'b10) is held only while loCmd stays high; once loCmd is low, loMode is 2'b00. Both gates stay disabled until three things are true: the pulse has ended, every cause is clear, and loCmd has been sampled low. The next loCmd high then gives 2'b01. Code 2'b11 never appears.
- R6: A low level on shutdownN forces loMode to 2'b00 (hard off, never soft) and hiGate to 0 one cycle later. If the line is not already being pulled, its falling edge starts a fault pulse. The gates stay off for as long as shutdownN is low, even after the pulse has ended.
- R7: If faultInN is low while the block itself is not pulling, both gates are off one cycle later, and the block does not start a pulse of its own.
- R8: uvLoAssert must persist for UV_FILT_CYC cycles, and a shorter run is ignored. Once accepted, it causes the same pulse and soft-off as R3. The low side stays blocked after that until uvLoRelease is seen high.
- R9: uvHiAssert must persist for UV_FILT_CYC cycles. Once accepted, it blocks hiGate only: there is no pulse, and loMode is unaffected. A later uvHiRelease high removes the block.
- R10: With no fault, loMode is 2'b01 when loCmd was high on the previous edge and 2'b00 otherwise. hiGate follows hiCmd from the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scDet | input | 1 | Short-circuit comparator flag |
| uvLoAssert | input | 1 | Low-side supply below lower threshold |
| uvLoRelease | input | 1 | Low-side supply above upper threshold |
| uvHiAssert | input | 1 | High-side supply below lower threshold |
| uvHiRelease | input | 1 | High-side supply above upper threshold |
| shutdownN | input | 1 | Active-low shutdown request |
| faultInN | input | 1 | Sensed level of the shared fault line |
| loCmd | input | 1 | Low-side command from the interlock |
| hiCmd | input | 1 | High-side command from the interlock |
| faultPull | output | 1 | Open-drain pull-down enable for the fault line |
| loMode | output | 2 | Low-side drive: 00 off, 01 on, 10 soft-off |
| hiGate | output | 1 | High-side gate enable |

## Verification
Random loCmd/hiCmd toggling mixed with random short-circuit glitches shorter than the filter shows two things: normal drive follows the commands exactly, and spikes never trip the block. Directed runs go through each fault source in turn: short circuit, low and high undervoltage, shutdown, and external pull-down. These show soft-off apart from hard-off, and pulse-producing sources apart from those that do not produce a pulse. A second event injected part-way through a pulse separates "no stretch" from "retrigger". Restart sequences confirm that re-enable waits for the pulse to end, the cause to clear and loCmd to go low, or for the undervoltage release flag.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
  typedef enum logic [1:0] {
    LO_OFF  = 2'b00,
    LO_ON   = 2'b01,
    LO_SOFT = 2'b10
  } loMode_e;

  // control -> datapath
  typedef struct packed {
    logic pulseStart;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic scHit;
    logic scQual;
    logic uvLoHit;
    logic uvLoBlock;
    logic uvHiBlock;
    logic pulseActive;
  } dpStatus_t;
endpackage

// File: rtl/gfs_persist.sv
module gfs_persist #(
  parameter int THRESH = 30
) (
  input  logic clk,
  input  logic rstN,
  input  logic raw,
  output logic qual,
  output logic hit
);
  localparam int W = $clog2(THRESH + 1);
  localparam logic [W-1:0] LIM  = W'(THRESH);
  localparam logic [W-1:0] LIM1 = W'(THRESH - 1);

  logic [W-1:0] cnt;
  logic hitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      hitQ <= 1'b0;
    end else begin
      hitQ <= 1'b0;
      if (!raw) begin
        cnt <= '0;
      end else if (cnt != LIM) begin
        cnt <= cnt + 1'b1;
        if (cnt == LIM1) hitQ <= 1'b1;
      end
    end
  end

  assign qual = (cnt == LIM);
  assign hit  = hitQ;
endmodule

// File: rtl/gfs_uvlock.sv
module gfs_uvlock #(
  parameter int THRESH = 1600
) (
  input  logic clk,
  input  logic rstN,
  input  logic assertRaw,
  input  logic releaseRaw,
  output logic block,
  output logic hit
);
  logic qual;
  logic hitInt;
  logic blockQ;

  gfs_persist #(.THRESH(THRESH)) uFilt (
    .clk (clk),
    .rstN(rstN),
    .raw (assertRaw),
    .qual(qual),
    .hit (hitInt)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          blockQ <= 1'b1;
    else if (hitInt)                    blockQ <= 1'b1;
    else if (releaseRaw && !assertRaw)  blockQ <= 1'b0;
  end

  assign block = blockQ | qual;
  assign hit   = hitInt;
endmodule

// File: rtl/gfs_datapath.sv
module gfs_datapath
  import gfs_pkg::*;
#(
  parameter int SC_FILT_CYC = 30,
  parameter int UV_FILT_CYC = 1600,
  parameter int PULSE_CYC   = 10000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scDet,
  input  logic [1:0] uvAssert,   // [0] low side, [1] high side
  input  logic [1:0] uvRelease,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] PLAST = PW'(PULSE_CYC - 1);

  logic scQual, scHit;
  logic [1:0] uvBlock, uvHit;
  logic [PW-1:0] pulseCnt;
  logic pulseActive;

  gfs_persist #(.THRESH(SC_FILT_CYC)) uScFilt (
    .clk (clk),
    .rstN(rstN),
    .raw (scDet),
    .qual(scQual),
    .hit (scHit)
  );

  for (genvar g = 0; g < 2; g++) begin : gUv
    gfs_uvlock #(.THRESH(UV_FILT_CYC)) uLock (
      .clk       (clk),
      .rstN      (rstN),
      .assertRaw (uvAssert[g]),
      .releaseRaw(uvRelease[g]),
      .block     (uvBlock[g]),
      .hit       (uvHit[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseActive <= 1'b0;
      pulseCnt    <= '0;
    end else if (strobe.pulseStart && !pulseActive) begin
      pulseActive <= 1'b1;
      pulseCnt    <= '0;
    end else if (pulseActive) begin
      if (pulseCnt == PLAST) pulseActive <= 1'b0;
      else                   pulseCnt    <= pulseCnt + 1'b1;
    end
  end

  always_comb begin
    status.scHit       = scHit;
    status.scQual      = scQual;
    status.uvLoHit     = uvHit[0];
    status.uvLoBlock   = uvBlock[0];
    status.uvHiBlock   = uvBlock[1];
    status.pulseActive = pulseActive;
  end
endmodule

// File: rtl/gfs_control.sv
module gfs_control
  import gfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  status,
  input  logic       shutdownN,
  input  logic       faultInN,
  input  logic       loCmd,
  input  logic       hiCmd,
  output ctlStrobe_t strobe,
  output logic [1:0] loMode,
  output logic       hiGate
);
  logic sdSeen, tripped, softReq;
  logic sdActive, sdEdge, extFault, startEvt, softEvt;
  logic hardNow, effTrip, effSoft, causeLive, clearOk;
  loMode_e loNext, loQ;
  logic hiNext, hiQ;

  always_comb begin
    sdActive  = !shutdownN;
    sdEdge    = sdActive && !sdSeen;
    extFault  = !faultInN && !status.pulseActive;
    softEvt   = status.scHit || status.uvLoHit;
    startEvt  = softEvt || sdEdge;
    hardNow   = sdActive || extFault;
    effTrip   = tripped || startEvt || extFault;
    effSoft   = softReq || softEvt;
    causeLive = status.scQual || status.uvLoBlock || sdActive || extFault;
    clearOk   = tripped && !status.pulseActive && !causeLive && !loCmd;
    strobe.pulseStart = startEvt && !status.pulseActive;

    if (hardNow)               loNext = LO_OFF;
    else if (effTrip)          loNext = (effSoft && loCmd) ? LO_SOFT : LO_OFF;
    else if (status.uvLoBlock) loNext = LO_OFF;
    else                       loNext = loCmd ? LO_ON : LO_OFF;

    hiNext = hiCmd && !effTrip && !hardNow && !status.uvHiBlock && !status.uvLoBlock;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdSeen  <= 1'b0;
      tripped <= 1'b0;
      softReq <= 1'b0;
      loQ     <= LO_OFF;
      hiQ     <= 1'b0;
    end else begin
      sdSeen <= sdActive;
      if (startEvt || extFault) tripped <= 1'b1;
      else if (clearOk)         tripped <= 1'b0;
      if (softEvt)                   softReq <= 1'b1;
      else if (!loCmd || clearOk)    softReq <= 1'b0;
      loQ <= loNext;
      hiQ <= hiNext;
    end
  end

  assign loMode = loQ;
  assign hiGate = hiQ;
endmodule

// File: rtl/gate_fault_seq.sv
module gate_fault_seq
  import gfs_pkg::*;
#(
  parameter int SC_FILT_CYC = 30,
  parameter int UV_FILT_CYC = 1600,
  parameter int PULSE_CYC   = 10000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scDet,
  input  logic       uvLoAssert,
  input  logic       uvLoRelease,
  input  logic       uvHiAssert,
  input  logic       uvHiRelease,
  input  logic       shutdownN,
  input  logic       faultInN,
  input  logic       loCmd,
  input  logic       hiCmd,
  output logic       faultPull,
  output logic [1:0] loMode,
  output logic       hiGate
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  gfs_datapath #(
    .SC_FILT_CYC(SC_FILT_CYC),
    .UV_FILT_CYC(UV_FILT_CYC),
    .PULSE_CYC  (PULSE_CYC)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .scDet    (scDet),
    .uvAssert ({uvHiAssert, uvLoAssert}),
    .uvRelease({uvHiRelease, uvLoRelease}),
    .strobe   (strobe),
    .status   (status)
  );

  gfs_control uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .status   (status),
    .shutdownN(shutdownN),
    .faultInN (faultInN),
    .loCmd    (loCmd),
    .hiCmd    (hiCmd),
    .strobe   (strobe),
    .loMode   (loMode),
    .hiGate   (hiGate)
  );

  assign faultPull = status.pulseActive;
endmodule

// File: rtl/gfs_checker.sv
module gfs_checker #(
  parameter int PULSE_CYC = 10000
) (
  input logic       clk,
  input logic       rstN,
  input logic       shutdownN,
  input logic       faultInN,
  input logic       loCmd,
  input logic       hiCmd,
  input logic       faultPull,
  input logic [1:0] loMode,
  input logic       hiGate
);
  localparam int CW = $clog2(PULSE_CYC + 2);
  logic [CW-1:0] pullRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pullRun <= '0;
    else if (!faultPull)      pullRun <= '0;
    else if (pullRun <= CW'(PULSE_CYC)) pullRun <= pullRun + 1'b1;
  end

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    pullRun <= CW'(PULSE_CYC));

  // R6
  sd_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shutdownN |=> (loMode == 2'b00 && !hiGate));

  // R6
  sd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(shutdownN) && !faultPull) |=> faultPull);

  // R7
  ext_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!faultInN && !faultPull) |=> (loMode == 2'b00 && !hiGate));

  // R5
  soft_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loMode == 2'b10) |-> $past(loCmd));

  // R5
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    loMode != 2'b11);

  // R10
  hi_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiGate |-> $past(hiCmd));
endmodule

bind gate_fault_seq gfs_checker #(.PULSE_CYC(PULSE_CYC)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .shutdownN(shutdownN),
  .faultInN (faultInN),
  .loCmd    (loCmd),
  .hiCmd    (hiCmd),
  .faultPull(faultPull),
  .loMode   (loMode),
  .hiGate   (hiGate)
);

// File: tb/sim_gate_fault_seq.sv
module sim_gate_fault_seq;
  localparam int SC = 6;
  localparam int UV = 10;
  localparam int PL = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scDet = 0, uvLoAssert = 0, uvLoRelease = 0, uvHiAssert = 0, uvHiRelease = 0;
  logic shutdownN = 1, loCmd = 0, hiCmd = 0, extPull = 0;
  logic faultInN, faultPull, hiGate;
  logic [1:0] loMode;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  assign faultInN = ~(faultPull | extPull);

  gate_fault_seq #(.SC_FILT_CYC(SC), .UV_FILT_CYC(UV), .PULSE_CYC(PL)) u0 (
    .clk(clk), .rstN(rstN), .scDet(scDet),
    .uvLoAssert(uvLoAssert), .uvLoRelease(uvLoRelease),
    .uvHiAssert(uvHiAssert), .uvHiRelease(uvHiRelease),
    .shutdownN(shutdownN), .faultInN(faultInN),
    .loCmd(loCmd), .hiCmd(hiCmd),
    .faultPull(faultPull), .loMode(loMode), .hiGate(hiGate)
  );

  function automatic int expLo(bit cmd);
    return cmd ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitPulseEnd();
    for (int i = 0; i < PL + 5 && faultPull; i++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int pc;
    bit prevLo, prevHi;
    int glen;
    void'($urandom(32'd4242));

    // R1 reset state
    step(2);
    chk("R1 lo in reset", loMode, 0);
    chk("R1 hi in reset", hiGate, 0);
    chk("R1 pull in reset", faultPull, 0);
    rstN = 1'b1;
    loCmd = 1; hiCmd = 1;
    step(3);
    chk("R1 lo blocked before release", loMode, 0);
    chk("R1 hi blocked before release", hiGate, 0);
    uvLoRelease = 1; uvHiRelease = 1;
    step(2);
    uvLoRelease = 0; uvHiRelease = 0;
    chk("R1 lo after release", loMode, 1);
    chk("R1 hi after release", hiGate, 1);

    // R10 / R2 random commands with short-circuit glitches below the filter
    prevLo = loCmd; prevHi = hiCmd; glen = 0;
    for (int it = 0; it < 300; it++) begin
      step();
      chk("R10 lo follows cmd", loMode, expLo(prevLo));
      chk("R10 hi follows cmd", hiGate, int'(prevHi));
      chk("R2 glitch ignored", faultPull, 0);
      loCmd = 1'($urandom); hiCmd = 1'($urandom);
      prevLo = loCmd; prevHi = hiCmd;
      if (glen > 0) begin scDet = 1; glen--; end
      else if (scDet) scDet = 0;
      else if ($urandom % 4 == 0) begin
        glen = 1 + int'($urandom % (SC - 1));
        scDet = 1; glen--;
      end
    end
    scDet = 0; hiCmd = 0; loCmd = 1;
    step(2);

    // R2 counter restarts on a one-cycle drop
    scDet = 1; step(SC - 1);
    scDet = 0; step();
    scDet = 1; step(SC - 1);
    scDet = 0; step(2);
    chk("R2 restart lo", loMode, 1);
    chk("R2 restart pull", faultPull, 0);

    // R3 / R4 / R5 accepted short circuit
    scDet = 1;
    step(SC);
    chk("R3 not yet", loMode, 1);
    step();
    chk("R3 soft-off", loMode, 2);
    chk("R3 pull", faultPull, 1);
    scDet = 0; hiCmd = 1;
    pc = 1;
    step();
    chk("R3 hi blocked", hiGate, 0);
    if (faultPull) pc++;
    while (faultPull && pc < PL + 5) begin step(); if (faultPull) pc++; end
    chk("R4 pulse width", pc, PL);
    hiCmd = 0;
    step(2);
    chk("R5 soft held", loMode, 2);
    loCmd = 0; step();
    chk("R5 off after cmd low", loMode, 0);
    loCmd = 1; step();
    chk("R5 restart", loMode, 1);

    // R4 / R6 second event during pulse does not stretch it
    scDet = 1; step(SC + 1);
    chk("R4 pull start", faultPull, 1);
    scDet = 0; pc = 1;
    for (int i = 0; i < 10; i++) begin step(); if (faultPull) pc++; end
    shutdownN = 0;
    while (faultPull && pc < PL + 5) begin step(); if (faultPull) pc++; end
    chk("R4 no stretch", pc, PL);
    step(3);
    chk("R6 held off lo", loMode, 0);
    chk("R6 held off pull", faultPull, 0);
    shutdownN = 1; loCmd = 0; step();
    loCmd = 1; step();
    chk("R6 restart", loMode, 1);

    // R6 shutdown alone
    hiCmd = 1; step();
    chk("R10 hi on", hiGate, 1);
    shutdownN = 0; step();
    chk("R6 lo hard off", loMode, 0);
    chk("R6 hi off", hiGate, 0);
    chk("R6 pull", faultPull, 1);
    step(3);
    chk("R6 not soft", loMode, 0);
    shutdownN = 1; loCmd = 0;
    waitPulseEnd();
    step();
    loCmd = 1; step();
    chk("R6 recover", loMode, 1);

    // R7 external pull-down
    extPull = 1; step();
    chk("R7 lo off", loMode, 0);
    chk("R7 hi off", hiGate, 0);
    chk("R7 no own pull", faultPull, 0);
    step(5);
    chk("R7 still no own pull", faultPull, 0);
    extPull = 0; loCmd = 0; step();
    loCmd = 1; step();
    chk("R7 recover", loMode, 1);
    chk("R7 hi recover", hiGate, 1);

    // R8 low-side undervoltage
    hiCmd = 0;
    uvLoAssert = 1; step(UV - 1);
    uvLoAssert = 0; step(2);
    chk("R8 short ignored", loMode, 1);
    chk("R8 short no pull", faultPull, 0);
    uvLoAssert = 1; step(UV);
    chk("R8 not yet", loMode, 1);
    step();
    chk("R8 soft-off", loMode, 2);
    chk("R8 pull", faultPull, 1);
    uvLoAssert = 0; loCmd = 0;
    waitPulseEnd();
    step();
    loCmd = 1; step();
    chk("R8 blocked until release", loMode, 0);
    uvLoRelease = 1; loCmd = 0; step();
    uvLoRelease = 0; step();
    loCmd = 1; step();
    chk("R8 after release", loMode, 1);

    // R9 high-side undervoltage
    hiCmd = 1; step();
    chk("R9 hi on", hiGate, 1);
    uvHiAssert = 1; step(UV);
    chk("R9 not yet", hiGate, 1);
    step();
    chk("R9 hi blocked", hiGate, 0);
    chk("R9 no pull", faultPull, 0);
    chk("R9 lo unaffected", loMode, 1);
    uvHiAssert = 0; step();
    chk("R9 still blocked", hiGate, 0);
    uvHiRelease = 1; step();
    uvHiRelease = 0; step();
    chk("R9 after release", hiGate, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule